// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block is the digital heart of an integer-N frequency synthesizer. It runs on one fast system clock. The oscillator edges arrive as a one-cycle strobe, `osc_tick`, and the reference edges arrive as another, `ref_tick`. One programmable counter divides the oscillator strobe by a 15-bit ratio. A second counter divides the reference strobe by a ratio picked from a sparse code table. A three-state phase/frequency comparator watches the two divided pulses and issues up (source) and down (sink) commands to an external charge pump. It also reports the width of each pump pulse to a lock detector.

A 3-bit operating mode is loaded together with the reference code and a 2-bit pump-current code. The mode can override the comparator by forcing the pump to sink, to source or to stay off. It can release the tuning output to high impedance, and it selects what drives the auxiliary test clock output. The lock flag is only shown in the two run modes.

Comparator state machine (`pfd_e`):
- `PFD_IDLE`: no pump command. It moves to `PFD_UP` on a reference pulse alone and to `PFD_DN` on a divider pulse alone. If both pulses arrive together it stays in `PFD_IDLE` and reports a zero-width comparison.
- `PFD_UP`: the pump sources. It returns to `PFD_IDLE` when the divider pulse arrives (both edges seen). Further reference pulses keep it in `PFD_UP`.
- `PFD_DN`: the pump sinks. It returns to `PFD_IDLE` when the reference pulse arrives.

Mode states (`mode_e`):
- `MD_RUN` (000) and `MD_RUN_ALT` (100): the normal modes.
- `MD_SAFE` (001): the reset state.
- `MD_DIVTEST` (010) and `MD_REFTEST` (101): the test-clock modes.
- `MD_SINK` (011), `MD_SOURCE` (111) and `MD_OFF` (110): the forced pump modes.

Top module: `synth_core`

## Requirements
- R1: After reset the mode is 001. The pump sinks (`pump_dn`=1, `pump_up`=0), `vt_hiz`=1, `aux_out` follows `ref_lvl`, `lock_flag`=0 and `cp_level`=00. The main ratio is 64 and the reference ratio is 2.
- R2: The main divider emits one pulse per N oscillator ticks, where N is the last `div_word` written with `div_wr`. A written value below 64 is raised to 64. In mode 010, `aux_out` toggles once per divider pulse.
- R3: A `ref_code` written with `ctl_wr` sets the reference ratio as follows: 000→2, 001→4, 010→8, 101→16, 111→32. In mode 101, `aux_out` toggles once per reference-divider pulse.
- R4: Writing one of the codes 011, 100 or 110 leaves the previous reference ratio in force.
- R5: In modes 000, 100, 010 and 101 the pump follows the comparator. `pump_up` is held from a lone reference pulse until the next divider pulse. `pump_dn` is held from a lone divider pulse until the next reference pulse. Pulses that arrive together raise neither command.
- R6: Mode 011 forces sink (`pump_dn`=1, `pump_up`=0). Mode 111 forces source. Mode 110 drives both commands low. Mode 001 forces sink and sets `vt_hiz`.
- R7: `aux_out` is 0 in mode 000. It is the halved divider output in mode 010 and the halved reference-divider output in mode 101. In every other mode it follows `ref_lvl`.
- R8: A comparison is good when its pump pulse width in clock cycles is at most `lock_win`. Lock is set on the 16th consecutive good comparison. It is cleared by the first comparison that is not good.
- R9: `lock_flag` shows the lock state only in modes 000 and 100, and is 0 in all other modes.
- R10: `cp_level` presents the `cp_code` last written with `ctl_wr`, unchanged. A higher code selects a higher current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator edge |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| ref_lvl | input | 1 | Reference clock level, routed to the auxiliary output |
| div_wr | input | 1 | Load strobe for the main ratio |
| div_word | input | 15 | Main divider ratio |
| ctl_wr | input | 1 | Load strobe for mode, reference code and pump code |
| mode_word | input | 3 | Operating mode |
| ref_code | input | 3 | Reference ratio code |
| cp_code | input | 2 | Pump-current code |
| lock_win | input | 8 | Largest pump pulse width counted as good |
| pump_up | output | 1 | Charge-pump source command |
| pump_dn | output | 1 | Charge-pump sink command |
| vt_hiz | output | 1 | Release of the tuning output |
| cp_level | output | 2 | Pump-current level |
| aux_out | output | 1 | Auxiliary test clock |
| lock_flag | output | 1 | Lock indication |

## Verification
Every register in the block updates on the same edge that samples its strobe. A configuration write therefore shows at the outputs one clock after `ctl_wr` or `div_wr`. A divider pulse appears one clock after its terminal tick. The comparator state, and with it the pump commands, moves one clock after that pulse. The lock flag moves one further clock after the registered end of a comparison. The bench steps a behavioural model at every rising edge, using the same input values the design samples. It then compares all six outputs one time unit later, so each result is checked in exactly the cycle it is due. Directed period measurements on `aux_out` skip the first, possibly partial, period after a write.

// File: rtl/synth_pkg.sv
package synth_pkg;

    localparam int REF_RW = 6;

    typedef enum logic [2:0] {
        MD_RUN     = 3'b000,
        MD_SAFE    = 3'b001,
        MD_DIVTEST = 3'b010,
        MD_SINK    = 3'b011,
        MD_RUN_ALT = 3'b100,
        MD_REFTEST = 3'b101,
        MD_OFF     = 3'b110,
        MD_SOURCE  = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_e;

    // Reference ratio for a code; zero marks a code that must be refused.
    function automatic logic [REF_RW-1:0] ref_ratio_of(input logic [2:0] code);
        case (code)
            3'b000:  return REF_RW'(2);
            3'b001:  return REF_RW'(4);
            3'b010:  return REF_RW'(8);
            3'b101:  return REF_RW'(16);
            3'b111:  return REF_RW'(32);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/synth_div.sv
module synth_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse,
    output logic         half
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
            half  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt >= ratio - ONE) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                    half  <= ~half;
                end else begin
                    cnt <= cnt + ONE;
                end
            end
        end
    end

    // R2/R3: with a ratio of at least two, output pulses never touch
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R2/R3: the halved output changes only together with a pulse
    a_r3_half_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (half != $past(half)) |-> pulse);

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
    import synth_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_p,
    input  logic          div_p,
    output logic          up,
    output logic          dn,
    output logic          done,
    output logic [GW-1:0] width
);
    localparam logic [GW-1:0] ONE = GW'(1);

    pfd_e          state_q, state_d;
    logic          leave;
    logic [GW-1:0] gap_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        leave   = 1'b0;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_p && div_p)  leave   = 1'b1;
                else if (ref_p)      state_d = PFD_UP;
                else if (div_p)      state_d = PFD_DN;
            end
            PFD_UP: begin
                if (div_p) begin
                    state_d = PFD_IDLE;
                    leave   = 1'b1;
                end
            end
            PFD_DN: begin
                if (ref_p) begin
                    state_d = PFD_IDLE;
                    leave   = 1'b1;
                end
            end
            default: state_d = PFD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    // pulse width measurement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            done  <= 1'b0;
            width <= '0;
        end else begin
            done <= leave;
            if (leave) width <= (state_q == PFD_IDLE) ? '0 : gap_q;
            if (state_d == PFD_IDLE)      gap_q <= '0;
            else if (state_q == PFD_IDLE) gap_q <= ONE;
            else if (gap_q != '1)         gap_q <= gap_q + ONE;
        end
    end

    // outputs
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PFD_UP:  up = 1'b1;
            PFD_DN:  dn = 1'b1;
            default: ;
        endcase
    end

    // R5: a pending source command closes when the divider edge arrives
    a_r5_up_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (up && div_p) |=> (!up && done));

    // R5: coincident edges raise no command
    a_r5_coincident: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_p && div_p) |=> (!up && !dn));

endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
    parameter int GW     = 8,
    parameter int LOCK_N = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [GW-1:0] width,
    input  logic [GW-1:0] win,
    output logic          locked
);
    localparam int               LCW  = $clog2(LOCK_N + 1);
    localparam logic [LCW-1:0]   LMAX = LCW'(LOCK_N);
    localparam logic [LCW-1:0]   LPRE = LCW'(LOCK_N - 1);
    localparam logic [LCW-1:0]   LONE = LCW'(1);

    logic [LCW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (done) begin
            if (width <= win) begin
                if (run_q < LMAX)  run_q  <= run_q + LONE;
                if (run_q >= LPRE) locked <= 1'b1;
            end else begin
                run_q  <= '0;
                locked <= 1'b0;
            end
        end
    end

    // R8: one bad comparison drops lock
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (width > win)) |=> !locked);

    // R8: lock rises only on a good comparison
    a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(done) && ($past(width) <= $past(win))));

endmodule

// File: rtl/synth_core.sv
module synth_core
    import synth_pkg::*;
#(
    parameter int NW     = 15,
    parameter int GW     = 8,
    parameter int LOCK_N = 16,
    parameter int NMIN   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_tick,
    input  logic          ref_tick,
    input  logic          ref_lvl,
    input  logic          div_wr,
    input  logic [NW-1:0] div_word,
    input  logic          ctl_wr,
    input  logic [2:0]    mode_word,
    input  logic [2:0]    ref_code,
    input  logic [1:0]    cp_code,
    input  logic [GW-1:0] lock_win,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          vt_hiz,
    output logic [1:0]    cp_level,
    output logic          aux_out,
    output logic          lock_flag
);
    localparam logic [NW-1:0]     NMIN_V  = NW'(NMIN);
    localparam logic [REF_RW-1:0] RR_RST  = REF_RW'(2);

    mode_e             mode_q;
    logic [NW-1:0]     n_q;
    logic [REF_RW-1:0] rr_q, rr_new;
    logic [1:0]        cp_q;

    logic div_p, div_half, ref_p, ref_half;
    logic pfd_up, pfd_dn, cmp_done, locked;
    logic [GW-1:0] cmp_width;

    assign rr_new = ref_ratio_of(ref_code);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_SAFE;
            n_q    <= NMIN_V;
            rr_q   <= RR_RST;
            cp_q   <= '0;
        end else begin
            if (div_wr) n_q <= (div_word < NMIN_V) ? NMIN_V : div_word;
            if (ctl_wr) begin
                mode_q <= mode_e'(mode_word);
                cp_q   <= cp_code;
                if (rr_new != '0) rr_q <= rr_new;
            end
        end
    end

    synth_div #(.W(NW)) u_main_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick),
        .ratio (n_q),
        .pulse (div_p),
        .half  (div_half)
    );

    synth_div #(.W(REF_RW)) u_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .ratio (rr_q),
        .pulse (ref_p),
        .half  (ref_half)
    );

    synth_pfd #(.GW(GW)) u_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_p (ref_p),
        .div_p (div_p),
        .up    (pfd_up),
        .dn    (pfd_dn),
        .done  (cmp_done),
        .width (cmp_width)
    );

    synth_lock #(.GW(GW), .LOCK_N(LOCK_N)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (cmp_done),
        .width  (cmp_width),
        .win    (lock_win),
        .locked (locked)
    );

    // mode-driven outputs
    always_comb begin
        pump_up   = pfd_up;
        pump_dn   = pfd_dn;
        vt_hiz    = 1'b0;
        aux_out   = ref_lvl;
        lock_flag = 1'b0;
        unique case (mode_q)
            MD_RUN: begin
                aux_out   = 1'b0;
                lock_flag = locked;
            end
            MD_RUN_ALT: lock_flag = locked;
            MD_SAFE: begin
                pump_up = 1'b0;
                pump_dn = 1'b1;
                vt_hiz  = 1'b1;
            end
            MD_DIVTEST: aux_out = div_half;
            MD_REFTEST: aux_out = ref_half;
            MD_SINK: begin
                pump_up = 1'b0;
                pump_dn = 1'b1;
            end
            MD_SOURCE: begin
                pump_up = 1'b1;
                pump_dn = 1'b0;
            end
            MD_OFF: begin
                pump_up = 1'b0;
                pump_dn = 1'b0;
            end
            default: ;
        endcase
    end

    assign cp_level = cp_q;

    // R2: the main ratio never sits below its floor
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        n_q >= NMIN_V);

    // R4: a refused code leaves the reference ratio alone
    a_r4_keep_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (rr_new == '0)) |=> (rr_q == $past(rr_q)));

    // R6: a released tuning output always comes with a sinking pump
    a_r6_hiz_sink: assert property (@(posedge clk) disable iff (!rst_n)
        vt_hiz |-> (pump_dn && !pump_up));

    // R9: lock is never shown outside the run modes
    a_r9_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |-> (mode_q == MD_RUN || mode_q == MD_RUN_ALT));

endmodule

// File: tb/synth_core_tb.sv
module synth_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0, ref_tick = 1'b0, ref_lvl = 1'b0;
    logic        div_wr = 1'b0, ctl_wr = 1'b0;
    logic [14:0] div_word = 15'd64;
    logic [2:0]  mode_word = 3'b001, ref_code = 3'b000;
    logic [1:0]  cp_code = 2'b00;
    logic [7:0]  lock_win = 8'd255;
    logic        pump_up, pump_dn, vt_hiz, aux_out, lock_flag;
    logic [1:0]  cp_level;

    int tests = 0, fails = 0, cyc = 0;
    int osc_per = 0, ref_per = 0, osc_c = 0, ref_c = 0;

    synth_core u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ref_tick(ref_tick),
        .ref_lvl(ref_lvl), .div_wr(div_wr), .div_word(div_word),
        .ctl_wr(ctl_wr), .mode_word(mode_word), .ref_code(ref_code),
        .cp_code(cp_code), .lock_win(lock_win), .pump_up(pump_up),
        .pump_dn(pump_dn), .vt_hiz(vt_hiz), .cp_level(cp_level),
        .aux_out(aux_out), .lock_flag(lock_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // tick generators, driven away from the rising edge
    always @(negedge clk) begin
        if (osc_per == 0) osc_tick <= 1'b0;
        else begin
            osc_tick <= (osc_c == 0);
            osc_c <= (osc_c + 1 >= osc_per) ? 0 : osc_c + 1;
        end
        if (ref_per == 0) ref_tick <= 1'b0;
        else begin
            ref_tick <= (ref_c == 0);
            ref_c <= (ref_c + 1 >= ref_per) ? 0 : ref_c + 1;
        end
    end

    // behavioural reference model
    int m_mode, m_n, m_rr, m_cp;
    int m_dcnt, m_rcnt, m_pst, m_gap, m_err, m_lcnt;
    bit m_dp, m_dh, m_rp, m_rh, m_done, m_locked;

    function automatic int ratio_for(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            5: return 16;
            7: return 32;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_n = 64; m_rr = 2; m_cp = 0;
            m_dcnt = 0; m_rcnt = 0; m_pst = 0; m_gap = 0; m_err = 0; m_lcnt = 0;
            m_dp = 0; m_dh = 0; m_rp = 0; m_rh = 0; m_done = 0; m_locked = 0;
        end else begin
            int npst, ngap, nerr;
            bit ndone, ndp, nrp;
            // lock detector works on the finished comparison
            if (m_done) begin
                if (m_err <= int'(lock_win)) begin
                    if (m_lcnt >= 15) m_locked = 1;
                    if (m_lcnt < 16) m_lcnt++;
                end else begin
                    m_lcnt = 0; m_locked = 0;
                end
            end
            // comparator
            npst = m_pst; ngap = 0; nerr = m_err; ndone = 0;
            case (m_pst)
                0: if (m_rp && m_dp) begin ndone = 1; nerr = 0; end
                   else if (m_rp) begin npst = 1; ngap = 1; end
                   else if (m_dp) begin npst = 2; ngap = 1; end
                1: if (m_dp) begin npst = 0; ndone = 1; nerr = m_gap; end
                   else ngap = (m_gap < 255) ? m_gap + 1 : 255;
                default: if (m_rp) begin npst = 0; ndone = 1; nerr = m_gap; end
                   else ngap = (m_gap < 255) ? m_gap + 1 : 255;
            endcase
            m_pst = npst; m_gap = ngap; m_err = nerr; m_done = ndone;
            // dividers
            ndp = 0;
            if (osc_tick) begin
                if (m_dcnt >= m_n - 1) begin m_dcnt = 0; ndp = 1; m_dh = ~m_dh; end
                else m_dcnt++;
            end
            nrp = 0;
            if (ref_tick) begin
                if (m_rcnt >= m_rr - 1) begin m_rcnt = 0; nrp = 1; m_rh = ~m_rh; end
                else m_rcnt++;
            end
            m_dp = ndp; m_rp = nrp;
            // configuration
            if (div_wr) m_n = (int'(div_word) < 64) ? 64 : int'(div_word);
            if (ctl_wr) begin
                m_mode = int'(mode_word);
                m_cp = int'(cp_code);
                if (ratio_for(int'(ref_code)) != 0) m_rr = ratio_for(int'(ref_code));
            end
        end
        #1;
        if (rst_n) begin
            int eu, ed, ea, el;
            eu = (m_mode == 7) ? 1 : (m_mode == 1 || m_mode == 3 || m_mode == 6) ? 0 : int'(m_pst == 1);
            ed = (m_mode == 1 || m_mode == 3) ? 1 : (m_mode == 6 || m_mode == 7) ? 0 : int'(m_pst == 2);
            ea = (m_mode == 0) ? 0 : (m_mode == 2) ? int'(m_dh) : (m_mode == 5) ? int'(m_rh) : int'(ref_lvl);
            el = (m_mode == 0 || m_mode == 4) ? int'(m_locked) : 0;
            check("R5/R6 pump_up model", int'(pump_up), eu);
            check("R5/R6 pump_dn model", int'(pump_dn), ed);
            check("R6 vt_hiz model", int'(vt_hiz), int'(m_mode == 1));
            check("R7 aux_out model", int'(aux_out), ea);
            check("R8/R9 lock_flag model", int'(lock_flag), el);
            check("R10 cp_level model", int'(cp_level), m_cp);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic ctl(input int md, input int rc, input int cp);
        @(negedge clk);
        mode_word = 3'(md); ref_code = 3'(rc); cp_code = 2'(cp); ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic setn(input int n);
        @(negedge clk);
        div_word = 15'(n); div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // cycles between two consecutive changes of aux_out, after one sync change
    task automatic meas(output int per);
        logic prev;
        int c;
        @(posedge clk); #2; prev = aux_out;
        while (aux_out == prev) begin @(posedge clk); #2; end
        prev = aux_out; c = 0;
        while (aux_out == prev) begin @(posedge clk); #2; c++; end
        per = c;
    endtask

    task automatic watch_pump(input int n, output int ups, output int dns);
        ups = 0; dns = 0;
        repeat (n) begin
            @(posedge clk); #2;
            if (pump_up) ups++;
            if (pump_dn) dns++;
        end
    endtask

    initial begin
        int p, ups, dns;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R1 reset state
        check("R1 reset pump_dn", int'(pump_dn), 1);
        check("R1 reset pump_up", int'(pump_up), 0);
        check("R1 reset vt_hiz", int'(vt_hiz), 1);
        check("R1 reset lock_flag", int'(lock_flag), 0);
        check("R1 reset cp_level", int'(cp_level), 0);
        ref_lvl = 1'b1; #1;
        check("R1 reset aux follows ref_lvl", int'(aux_out), 1);
        ref_lvl = 1'b0;

        // R1 reset ratios seen through test clocks
        osc_per = 1; ref_per = 1;
        ctl(2, 3, 0);               // divider test, refused code keeps reset ÷2
        meas(p); check("R1 reset main ratio", p, 64);
        ctl(5, 4, 0);
        meas(p); check("R1 reset ref ratio", p, 2);

        // R10 pump current code
        ctl(6, 0, 2); @(posedge clk); #2;
        check("R10 cp_level 10", int'(cp_level), 2);
        ctl(6, 0, 3); @(posedge clk); #2;
        check("R10 cp_level 11", int'(cp_level), 3);

        // R2 main divider
        ctl(2, 0, 1);
        setn(100); meas(p); check("R2 ratio 100", p, 100);
        setn(10);  meas(p); check("R2 ratio below floor", p, 64);
        setn(71);  meas(p); check("R2 ratio 71", p, 71);

        // R3 / R4 reference table
        ctl(5, 1, 0); meas(p); check("R3 code 001", p, 4);
        ctl(5, 2, 0); meas(p); check("R3 code 010", p, 8);
        ctl(5, 5, 0); meas(p); check("R3 code 101", p, 16);
        ctl(5, 7, 0); meas(p); check("R3 code 111", p, 32);
        ctl(5, 6, 0); meas(p); check("R4 code 110 refused", p, 32);
        ctl(5, 3, 0); meas(p); check("R4 code 011 refused", p, 32);
        ctl(5, 0, 0); meas(p); check("R3 code 000", p, 2);

        // R6 forced modes
        ctl(3, 0, 0); watch_pump(200, ups, dns);
        check("R6 sink mode dn", dns, 200); check("R6 sink mode up", ups, 0);
        ctl(7, 0, 0); watch_pump(200, ups, dns);
        check("R6 source mode up", ups, 200); check("R6 source mode dn", dns, 0);
        ctl(6, 0, 0); watch_pump(200, ups, dns);
        check("R6 off mode", ups + dns, 0);

        // R7 auxiliary selection
        ctl(6, 0, 0);
        @(negedge clk); ref_lvl = 1'b1; @(posedge clk); #2;
        check("R7 other mode aux high", int'(aux_out), 1);
        @(negedge clk); ref_lvl = 1'b0; @(posedge clk); #2;
        check("R7 other mode aux low", int'(aux_out), 0);
        ctl(0, 0, 0); @(negedge clk); ref_lvl = 1'b1; @(posedge clk); #2;
        check("R7 mode 000 aux off", int'(aux_out), 0);
        ref_lvl = 1'b0;

        // R8 lock with a wide window, equal rates
        lock_win = 8'd255; ref_per = 32; setn(64);
        repeat (3000) @(posedge clk); #2;
        check("R8 lock after good comparisons", int'(lock_flag), 1);
        // R9 gating
        ctl(3, 0, 0); @(posedge clk); #2;
        check("R9 lock hidden in sink mode", int'(lock_flag), 0);
        ctl(4, 0, 0); @(posedge clk); #2;
        check("R9 lock shown in mode 100", int'(lock_flag), 1);

        // R5 reference faster: source pulses; then divider faster: sink pulses
        setn(100); watch_pump(3000, ups, dns);
        check("R5 ref leads gives up pulses", int'(ups > 0), 1);
        setn(64); @(negedge clk); ref_per = 64;
        watch_pump(3000, ups, dns);
        check("R5 div leads gives down pulses", int'(dns > 0), 1);

        // R8 narrow window and mismatch drop lock
        lock_win = 8'd0; setn(100); ref_per = 32;
        repeat (2000) @(posedge clk); #2;
        check("R8 lock cleared by wide pulse", int'(lock_flag), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule